// File: doc/BRIEF.md
# Polyphase Horizontal Image Scaler

This block resamples one line of a single image component (luma or one of the two chroma planes) along the horizontal axis. Pixels come in on a valid/ready stream and resampled pixels go out on another. Each output pixel is a weighted sum of five neighbouring input pixels. The weights come from a programmable bank that holds 32 sub-pixel phases of five signed coefficients each.

A fixed-point step value sets the ratio. It gives the number of input pixels advanced per output pixel, so 0.1 gives ten times enlargement and 5.0 gives one-fifth reduction. An accumulator adds the step once for each output pixel. Its integer part names the centre input pixel, and its top five fractional bits pick the coefficient phase. A `start` pulse latches the line length and the step and clears the accumulator. The block then takes in exactly that many pixels and produces the resampled line. Where the five-tap window reaches past either end of the line, the edge pixel is repeated in the missing positions. Coefficients are written through a simple write port while the block is idle. A coefficient of 256 stands for unity gain.

Top module: `hscale_poly`

## Requirements
- R1: After reset, `busy`, `in_ready` and `out_valid` are all low.
- R2: A `start` pulse while `busy` is low latches `line_len` (at least 1) and `step` (unsigned, 3 integer and 16 fractional bits, nonzero), clears the accumulator, and makes `busy` high on the next cycle. A `start` while `busy` is high has no effect on the line in progress.
- R3: Each line consumes exactly `line_len` input pixels, including any not needed for an output. `busy` falls only after the last output pixel has been issued and the last input pixel has been taken.
- R4: A line produces one output pixel for each k = 0, 1, 2, ... for which floor(k*step / 65536) < `line_len`, and no others.
- R5: Output k uses centre c = floor(k*step / 65536) and phase ph = bits [15:11] of (k*step mod 65536). It sums coef[ph][t] * p[c-2+t] for t = 0..4, and any index below 0 or above `line_len`-1 is clamped to the nearest edge pixel.
- R6: The sum is rounded by adding 128 and arithmetically shifting right by 8, then saturated to 0..255.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R8: A write with `coef_we` high stores `coef_wdata` at phase `coef_addr[7:3]`, tap `coef_addr[2:0]`. Writes whose tap field is 5, 6 or 7 have no effect on any coefficient.
- R9: `in_ready` is low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 8 | Phase in [7:3], tap in [2:0] |
| coef_wdata | input | 10 | Signed coefficient, 256 = unity |
| start | input | 1 | Begin a line (ignored while busy) |
| line_len | input | 11 | Input pixels in the line |
| step | input | 19 | Input pixels per output pixel, unsigned Q3.16 |
| in_valid | input | 1 | Input pixel valid |
| in_data | input | 8 | Input pixel |
| in_ready | output | 1 | Block accepts an input pixel |
| out_valid | output | 1 | Output pixel valid |
| out_data | output | 8 | Output pixel |
| out_ready | input | 1 | Downstream accepts the output pixel |
| busy | output | 1 | A line is in progress |

## Verification
After a `start` edge, `busy` is high at the next sample. The first output can be valid no earlier than four edges after the first input handshake: one edge loads the window, two shift it, and one registers the sum. Later outputs follow either one edge after the previous one, when the centre is unchanged, or after one edge per window shift. The bench therefore does not predict cycle numbers. It samples at the falling edge and matches every output handshake, in order, against a model value computed for that output index. This keeps the checks valid under random gaps on both streams. The end-of-line counts of inputs taken and outputs produced are checked once `busy` and `out_valid` are both low.

// File: rtl/hscale_poly.sv
module hscale_poly #(
  parameter int PW       = 8,
  parameter int CW       = 10,
  parameter int FB       = 16,
  parameter int SI       = 3,
  parameter int LEN_W    = 11,
  parameter int UNITY_SH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 coef_we,
  input  logic [7:0]           coef_addr,
  input  logic [CW-1:0]        coef_wdata,
  input  logic                 start,
  input  logic [LEN_W-1:0]     line_len,
  input  logic [SI+FB-1:0]     step,
  input  logic                 in_valid,
  input  logic [PW-1:0]        in_data,
  output logic                 in_ready,
  output logic                 out_valid,
  output logic [PW-1:0]        out_data,
  input  logic                 out_ready,
  output logic                 busy
);
  localparam int TAPS   = 5;
  localparam int PHASES = 32;
  localparam int PH_W   = $clog2(PHASES);
  localparam int TAP_W  = 3;
  localparam int AW     = LEN_W + 1 + FB;
  localparam int SUM_W  = CW + PW + 4;
  localparam int PMAX   = (1 << PW) - 1;

  logic signed [CW-1:0] coef_mem [PHASES][TAPS];
  logic [PW-1:0]        win [TAPS];
  logic [LEN_W-1:0]     len_q, nin;
  logic [SI+FB-1:0]     step_q;
  logic [AW-1:0]        acc;
  logic signed [LEN_W+1:0] pos;
  logic                 first, outs_done;

  wire [LEN_W:0]        ctr    = acc[AW-1:FB];
  wire [PH_W-1:0]       phase  = acc[FB-1 -: PH_W];
  wire signed [LEN_W+1:0] ctr_s = {1'b0, ctr};
  wire                  more_in = nin < len_q;
  wire                  behind  = pos < ctr_s;
  wire [AW-1:0]         acc_nx  = acc + AW'(step_q);
  wire                  emit    = busy & ~first & ~outs_done & ~behind & (~out_valid | out_ready);

  assign in_ready = busy & (first | (outs_done ? more_in : (behind & more_in)));

  wire [TAP_W-1:0] wr_tap = coef_addr[TAP_W-1:0];
  wire [PH_W-1:0]  wr_ph  = coef_addr[TAP_W +: PH_W];

  always_ff @(posedge clk)
    if (coef_we && wr_tap < TAP_W'(TAPS))
      coef_mem[wr_ph][wr_tap] <= coef_wdata;

  logic signed [SUM_W-1:0] sum, rnd;
  logic [PW-1:0]           res;

  always_comb begin
    sum = '0;
    for (int t = 0; t < TAPS; t++)
      sum = sum + SUM_W'($signed(coef_mem[phase][t]) * $signed({1'b0, win[t]}));
    rnd = (sum + SUM_W'(1 << (UNITY_SH - 1))) >>> UNITY_SH;
    if (rnd < 0)                      res = '0;
    else if (rnd > SUM_W'(PMAX))      res = PW'(PMAX);
    else                              res = rnd[PW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; first <= 1'b0; outs_done <= 1'b0;
      len_q <= '0; step_q <= '0; acc <= '0; nin <= '0; pos <= '0;
      out_valid <= 1'b0; out_data <= '0;
      for (int t = 0; t < TAPS; t++) win[t] <= '0;
    end else begin
      out_valid <= emit | (out_valid & ~out_ready);
      if (!busy) begin
        if (start) begin
          busy <= 1'b1; first <= 1'b1; outs_done <= 1'b0;
          len_q <= line_len; step_q <= step; acc <= '0; nin <= '0;
        end
      end else if (first) begin
        if (in_valid) begin
          for (int t = 0; t < TAPS; t++) win[t] <= in_data;
          nin <= LEN_W'(1); pos <= -(LEN_W+2)'(2); first <= 1'b0;
        end
      end else if (outs_done) begin
        if (!more_in)      busy <= 1'b0;
        else if (in_valid) nin  <= nin + 1'b1;
      end else if (behind) begin
        if (!more_in || in_valid) begin
          for (int t = 0; t < TAPS-1; t++) win[t] <= win[t+1];
          win[TAPS-1] <= more_in ? in_data : win[TAPS-1];
          pos <= pos + 1'b1;
          if (more_in) nin <= nin + 1'b1;
        end
      end else if (emit) begin
        out_data <= res;
        acc      <= acc_nx;
        if (acc_nx[AW-1:FB] >= {1'b0, len_q}) outs_done <= 1'b1;
      end
    end
  end
endmodule

module hscale_poly_chk #(
  parameter int PW    = 8,
  parameter int LEN_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PW-1:0]    out_data,
  input logic [LEN_W-1:0] len_q
);
  logic [LEN_W:0] taken;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  taken <= '0;
    else if (start && !busy)     taken <= '0;
    else if (in_valid && in_ready) taken <= taken + 1'b1;

  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_idle_no_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !in_ready);

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  assert_in_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> taken <= {1'b0, len_q});
endmodule

bind hscale_poly hscale_poly_chk #(.PW(PW), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .len_q(len_q)
);

// File: tb/hscale_poly_test.sv
module hscale_poly_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic coef_we = 1'b0;
  logic [7:0] coef_addr = '0;
  logic [9:0] coef_wdata = '0;
  logic start = 1'b0;
  logic [10:0] line_len = '0;
  logic [18:0] step = '0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_ready, busy;
  logic [7:0] out_data;

  int errors = 0, checks = 0, cycles = 0;
  bit timed_out = 0;
  int cm [32][5];
  int pix [64];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) timed_out = 1;
  end

  hscale_poly uut (
    .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_wdata(coef_wdata), .start(start), .line_len(line_len), .step(step),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expv(int k, longint stp, int n);
    longint x = longint'(k) * stp;
    int c  = int'(x >>> 16);
    int ph = int'((x >>> 11) & 31);
    int s  = 0;
    for (int t = 0; t < 5; t++) begin
      int idx = c - 2 + t;
      if (idx < 0) idx = 0;
      if (idx > n - 1) idx = n - 1;
      s += cm[ph][t] * pix[idx];
    end
    s = (s + 128) >>> 8;
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return s;
  endfunction

  function automatic int exp_count(longint stp, int n);
    int m = 0;
    while (((longint'(m) * stp) >>> 16) < n) m++;
    return m;
  endfunction

  task automatic wr_coef(input int ph, input int tap, input int val);
    @(negedge clk);
    coef_we = 1'b1; coef_addr = 8'((ph << 3) | tap); coef_wdata = 10'(val);
    if (tap < 5) cm[ph][tap] = val;
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  // mode 0 identity, 1 random, 2 all max, 3 all min; R8: junk written to taps 5..7
  task automatic load_bank(input int mode);
    for (int ph = 0; ph < 32; ph++) begin
      for (int t = 0; t < 5; t++) begin
        int v;
        case (mode)
          0: v = (t == 2) ? 256 : 0;
          1: v = int'($urandom_range(400)) - 150;
          2: v = 511;
          default: v = -512;
        endcase
        wr_coef(ph, t, v);
      end
      for (int t = 5; t < 8; t++) wr_coef(ph, t, int'($urandom_range(1023)) - 512);
    end
  endtask

  task automatic run_line(input int n, input int stp, input bit poke);
    int idx = 0, k = 0, cyc = 0, m;
    for (int i = 0; i < n; i++) pix[i] = int'($urandom_range(255));
    m = exp_count(longint'(stp), n);
    @(negedge clk);
    start = 1'b1; line_len = 11'(n); step = 19'(stp);
    @(negedge clk);
    start = 1'b0;
    #1;
    check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    forever begin
      if (timed_out) break;
      in_valid  = (idx < n) && ($urandom_range(3) != 0);
      in_data   = (idx < n) ? 8'(pix[idx]) : 8'h00;
      out_ready = ($urandom_range(2) != 0);
      start     = poke && (cyc == 5);
      if (poke) line_len = 11'd3;
      #1;
      if (in_valid && in_ready) idx++;
      if (out_valid && out_ready) begin
        if (k >= m) check(0, "R4 extra output", k, m);
        else check(int'(out_data) == expv(k, longint'(stp), n), "R5 R6 R8 output value",
                   int'(out_data), expv(k, longint'(stp), n));
        k++;
      end
      if (!busy && !out_valid && cyc > 0) break;
      cyc++;
      @(negedge clk);
    end
    start = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    check(k == m, "R4 output count", k, m);
    check(idx == n, "R3 inputs consumed", idx, n);
    #1;
    check(!in_ready, "R9 idle not ready", int'(in_ready), 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy && !in_ready && !out_valid, "R1 reset state",
          int'({busy, in_ready, out_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !in_ready && !out_valid, "R1 after reset release",
          int'({busy, in_ready, out_valid}), 0);

    load_bank(0);
    run_line(16, 65536, 0);
    load_bank(1);
    run_line(41, 327680, 0);
    run_line(9, 6554, 0);
    run_line(1, 30000, 0);
    run_line(30, 90000, 1);
    load_bank(2);
    run_line(6, 65536, 0);
    load_bank(3);
    run_line(6, 65536, 0);
    load_bank(1);
    for (int i = 0; i < 8; i++)
      run_line(int'($urandom_range(48, 1)), int'($urandom_range(327680, 6554)), 0);

    if (timed_out) check(0, "watchdog", cycles, WATCHDOG);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule